// File: doc/BRIEF.md
# Dual-Channel UART Register Access Decoder

This block sits between a simple asynchronous-style host bus and the register files of two UART channels. For each host access it works out which channel, or both, is addressed and which physical register is reached. Only eight addresses exist, so the same address is reused in several banks. The bank is chosen by the addressed channel's current line-control value, by a level-select feature bit, by whether that channel's divisor is zero, and by the access direction.

Writes are taken on the rising edge of the write strobe. They are presented to each channel's register file as a one-cycle write enable, together with a register code, the data byte and a bit mask. The mask holds back the protected enhanced bits while that channel's enhanced-write unlock is clear. When the broadcast control is set, one write reaches both channels, and each channel decodes the address against its own line-control value.

Reads are combinational. While a read is active, the block reports the register code and the channel being read and drives the returned byte onto the data output. At all other times the output is released.

Top module: `uart2_regdec`

## Requirements
- R1: With `cs_n` low, `chan_sel`=1 addresses channel A and `chan_sel`=0 addresses channel B, for both reads and writes.
- R2: When `bcast_en` is 1, a write with `cs_n` low raises both `wr_en_a` and `wr_en_b` in the same cycle. Each channel's register code is decoded from that channel's own line-control value.
- R3: While `bcast_en` is 1, a read still returns the channel chosen by `chan_sel`, shown on `rd_ch_a` and `dout`.
- R4: Register codes: NONE 0, RXD 1, TXD 2, IEN 3, IST 4, FCT 5, LCT 6, MCT 7, LST 8, MST 9, SCR 10, DIVL 11, DIVH 12, ALT 13, EXT 14, XON1 15, XON2 16, XOFF1 17, XOFF2 18, MSEL 19, FLVL 20. When line-control bit 7 is 0, addresses 1 to 6 map to IEN, (IST/FCT), LCT, MCT, LST and MST.
- R5: When line-control bit 7 is 1 and the value is not 0xBF, address 0 maps to DIVL and address 1 to DIVH. Address 2 maps to ALT only while that channel's `div_zero` is 1; otherwise it falls back to IST/FCT. Addresses 3 to 7 keep their standard mapping.
- R6: When line-control equals 0xBF, addresses 0 to 7 map in order to DIVL, DIVH, EXT, LCT, XON1, XON2, XOFF1 and XOFF2.
- R7: In the standard bank, address 7 maps to SCR when the channel's `lvl_sel` is 0. When `lvl_sel` is 1 it maps to MSEL on writes and FLVL on reads.
- R8: A write takes effect only on a rising edge of `wr_n` with `cs_n` low. Nothing is issued while the strobe is low. The write enable is high for exactly one clock, in the cycle after the clock edge that first sees `wr_n` high. `wr_data` carries the byte held while the strobe was low.
- R9: While `cs_n` and `rd_n` are both low, `dout_oe` is 1 and `dout` carries the selected channel's `rd_data`. Otherwise `dout_oe` is 0 and `dout` is 0.
- R10: When a channel's `ext_unlock` is 0, its write mask is 0x0F for IEN, 0xCF for FCT and 0x1F for MCT. In every other case the mask is 0xFF.
- R11: A write to a read-only location (address 5 or 6 in the standard bank) raises no write enable.
- R12: Address 0 in the standard bank maps to RXD on reads and TXD on writes. Address 2 maps to IST on reads and FCT on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| chan_sel | input | 1 | 1 selects channel A, 0 selects channel B |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address |
| wdata | input | 8 | Host write data |
| lcr_a | input | 8 | Channel A line-control value |
| lcr_b | input | 8 | Channel B line-control value |
| div_zero_a | input | 1 | Channel A divisor bytes both zero |
| div_zero_b | input | 1 | Channel B divisor bytes both zero |
| lvl_sel_a | input | 1 | Channel A level-select feature bit |
| lvl_sel_b | input | 1 | Channel B level-select feature bit |
| ext_unlock_a | input | 1 | Channel A enhanced-write unlock |
| ext_unlock_b | input | 1 | Channel B enhanced-write unlock |
| bcast_en | input | 1 | Broadcast write control |
| rd_data_a | input | 8 | Read data returned by channel A |
| rd_data_b | input | 8 | Read data returned by channel B |
| wr_en_a | output | 1 | Channel A write enable pulse |
| wr_reg_a | output | 5 | Channel A register code |
| wr_mask_a | output | 8 | Channel A write bit mask |
| wr_en_b | output | 1 | Channel B write enable pulse |
| wr_reg_b | output | 5 | Channel B register code |
| wr_mask_b | output | 8 | Channel B write bit mask |
| wr_data | output | 8 | Captured write data |
| rd_reg | output | 5 | Register code of the active read |
| rd_ch_a | output | 1 | Active read targets channel A |
| dout | output | 8 | Read data to the host |
| dout_oe | output | 1 | Read data output enable |

## Verification
The bench walks every address through each bank. It watches for two failure modes: a decoder that checks only bit 7 would map address 2 to the wrong register at 0xBF, and one that ignores `div_zero` would expose the alternate register while the divisor is still in use. A broadcast write is issued with the two channels in different banks, which catches a decoder that reuses one channel's decode for both. A broadcast read is issued with `chan_sel` low, which catches one that returns channel A whenever broadcast is on. Write timing is checked while the strobe is still low and again one cycle after the pulse, so an enable on the falling edge or one that lasts two cycles is reported. Writes to the status addresses and writes with chip select high confirm that ignored accesses raise no enable.

// File: rtl/uart2_regdec_pkg.sv
package uart2_regdec_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int REG_W    = 5;
    localparam int NUM_CH   = 2;
    localparam logic [DATA_W-1:0] EXT_BANK_KEY = 8'hBF;

    typedef enum logic [REG_W-1:0] {
        RG_NONE  = 5'd0,
        RG_RXD   = 5'd1,
        RG_TXD   = 5'd2,
        RG_IEN   = 5'd3,
        RG_IST   = 5'd4,
        RG_FCT   = 5'd5,
        RG_LCT   = 5'd6,
        RG_MCT   = 5'd7,
        RG_LST   = 5'd8,
        RG_MST   = 5'd9,
        RG_SCR   = 5'd10,
        RG_DIVL  = 5'd11,
        RG_DIVH  = 5'd12,
        RG_ALT   = 5'd13,
        RG_EXT   = 5'd14,
        RG_XON1  = 5'd15,
        RG_XON2  = 5'd16,
        RG_XOFF1 = 5'd17,
        RG_XOFF2 = 5'd18,
        RG_MSEL  = 5'd19,
        RG_FLVL  = 5'd20
    } reg_id_e;

    // Per-channel bank configuration seen by the decoder
    typedef struct packed {
        logic [DATA_W-1:0] lcr;
        logic              div_zero;
        logic              lvl_sel;
        logic              ext_unlock;
    } bank_cfg_t;

    // Standard bank; access direction splits shared addresses
    function automatic reg_id_e std_map(input logic [ADDR_W-1:0] a,
                                        input logic lvl, input logic is_wr);
        reg_id_e r;
        case (a)
            3'd0:    r = is_wr ? RG_TXD : RG_RXD;
            3'd1:    r = RG_IEN;
            3'd2:    r = is_wr ? RG_FCT : RG_IST;
            3'd3:    r = RG_LCT;
            3'd4:    r = RG_MCT;
            3'd5:    r = is_wr ? RG_NONE : RG_LST;
            3'd6:    r = is_wr ? RG_NONE : RG_MST;
            default: r = lvl ? (is_wr ? RG_MSEL : RG_FLVL) : RG_SCR;
        endcase
        return r;
    endfunction

    function automatic reg_id_e ext_map(input logic [ADDR_W-1:0] a);
        reg_id_e r;
        case (a)
            3'd0:    r = RG_DIVL;
            3'd1:    r = RG_DIVH;
            3'd2:    r = RG_EXT;
            3'd3:    r = RG_LCT;
            3'd4:    r = RG_XON1;
            3'd5:    r = RG_XON2;
            3'd6:    r = RG_XOFF1;
            default: r = RG_XOFF2;
        endcase
        return r;
    endfunction

    // Bits an access may change while the enhanced unlock is clear
    function automatic logic [DATA_W-1:0] lock_mask(input reg_id_e r,
                                                    input logic unlock);
        logic [DATA_W-1:0] m;
        m = '1;
        if (!unlock) begin
            case (r)
                RG_IEN:  m = 8'h0F;
                RG_FCT:  m = 8'hCF;
                RG_MCT:  m = 8'h1F;
                default: m = '1;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/uart2_addr_map.sv
module uart2_addr_map
    import uart2_regdec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  bank_cfg_t         cfg,
    input  logic              is_wr,
    output reg_id_e           reg_id
);
    logic in_ext_bank;
    logic in_div_bank;
    reg_id_e std_id;

    assign in_ext_bank = (cfg.lcr == EXT_BANK_KEY);
    assign in_div_bank = cfg.lcr[DATA_W-1] && !in_ext_bank;
    assign std_id      = std_map(addr, cfg.lvl_sel, is_wr);

    always_comb begin
        if (in_ext_bank) begin
            reg_id = ext_map(addr);
        end else if (in_div_bank) begin
            case (addr)
                3'd0:    reg_id = RG_DIVL;
                3'd1:    reg_id = RG_DIVH;
                3'd2:    reg_id = cfg.div_zero ? RG_ALT : std_id;
                default: reg_id = std_id;
            endcase
        end else begin
            reg_id = std_id;
        end
    end
endmodule

// File: rtl/uart2_strobe_cap.sv
module uart2_strobe_cap
    import uart2_regdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              cs_n,
    input  logic              chan_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rise,
    output logic              cap_cs,
    output logic              cap_ch_a,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    logic wr_n_q;

    // Address, select and data are held from the strobe-low phase
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q   <= 1'b1;
            cap_cs   <= 1'b0;
            cap_ch_a <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            wr_n_q <= wr_n;
            if (!wr_n) begin
                cap_cs   <= !cs_n;
                cap_ch_a <= chan_sel;
                cap_addr <= addr;
                cap_data <= wdata;
            end
        end
    end

    assign rise = !wr_n_q && wr_n;

    p_rise_after_low_r8: assert property (@(posedge clk) disable iff (rst)
        rise |-> $past(!wr_n));
endmodule

// File: rtl/uart2_rd_path.sv
module uart2_rd_path
    import uart2_regdec_pkg::*;
(
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              chan_sel,
    input  logic [DATA_W-1:0] rd_data_a,
    input  logic [DATA_W-1:0] rd_data_b,
    output logic              rd_active,
    output logic              rd_ch_a,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    assign rd_active = !cs_n && !rd_n;
    assign rd_ch_a   = rd_active && chan_sel;
    assign dout_oe   = rd_active;
    assign dout      = !rd_active ? '0 : (chan_sel ? rd_data_a : rd_data_b);
endmodule

// File: rtl/uart2_regdec.sv
module uart2_regdec
    import uart2_regdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        chan_sel,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    input  logic [7:0]  lcr_a,
    input  logic [7:0]  lcr_b,
    input  logic        div_zero_a,
    input  logic        div_zero_b,
    input  logic        lvl_sel_a,
    input  logic        lvl_sel_b,
    input  logic        ext_unlock_a,
    input  logic        ext_unlock_b,
    input  logic        bcast_en,
    input  logic [7:0]  rd_data_a,
    input  logic [7:0]  rd_data_b,
    output logic        wr_en_a,
    output logic [4:0]  wr_reg_a,
    output logic [7:0]  wr_mask_a,
    output logic        wr_en_b,
    output logic [4:0]  wr_reg_b,
    output logic [7:0]  wr_mask_b,
    output logic [7:0]  wr_data,
    output logic [4:0]  rd_reg,
    output logic        rd_ch_a,
    output logic [7:0]  dout,
    output logic        dout_oe
);
    // Index 0 is channel A, index 1 is channel B
    bank_cfg_t         cfg_v  [NUM_CH];
    reg_id_e           wdec_v [NUM_CH];
    logic              wen_v  [NUM_CH];
    reg_id_e           wreg_v [NUM_CH];
    logic [DATA_W-1:0] wmsk_v [NUM_CH];

    assign cfg_v[0] = '{lcr: lcr_a, div_zero: div_zero_a,
                        lvl_sel: lvl_sel_a, ext_unlock: ext_unlock_a};
    assign cfg_v[1] = '{lcr: lcr_b, div_zero: div_zero_b,
                        lvl_sel: lvl_sel_b, ext_unlock: ext_unlock_b};

    logic              rise;
    logic              cap_cs;
    logic              cap_ch_a;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    uart2_strobe_cap u_cap (
        .clk      (clk),
        .rst      (rst),
        .wr_n     (wr_n),
        .cs_n     (cs_n),
        .chan_sel (chan_sel),
        .addr     (addr),
        .wdata    (wdata),
        .rise     (rise),
        .cap_cs   (cap_cs),
        .cap_ch_a (cap_ch_a),
        .cap_addr (cap_addr),
        .cap_data (cap_data)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        uart2_addr_map u_wmap (
            .addr   (cap_addr),
            .cfg    (cfg_v[g]),
            .is_wr  (1'b1),
            .reg_id (wdec_v[g])
        );

        assign hit = rise && cap_cs && (bcast_en || (cap_ch_a == (g == 0)))
                     && (wdec_v[g] != RG_NONE);

        always_ff @(posedge clk) begin
            if (rst) begin
                wen_v[g]  <= 1'b0;
                wreg_v[g] <= RG_NONE;
                wmsk_v[g] <= '0;
            end else begin
                wen_v[g]  <= hit;
                wreg_v[g] <= hit ? wdec_v[g] : RG_NONE;
                wmsk_v[g] <= hit ? lock_mask(wdec_v[g], cfg_v[g].ext_unlock) : '0;
            end
        end

        p_ro_no_write_r11: assert property (@(posedge clk) disable iff (rst)
            wen_v[g] |-> (wreg_v[g] != RG_LST && wreg_v[g] != RG_MST
                          && wreg_v[g] != RG_NONE));
        p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
            wen_v[g] |=> !wen_v[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) wr_data <= '0;
        else if (rise) wr_data <= cap_data;
    end

    assign wr_en_a   = wen_v[0];
    assign wr_reg_a  = wreg_v[0];
    assign wr_mask_a = wmsk_v[0];
    assign wr_en_b   = wen_v[1];
    assign wr_reg_b  = wreg_v[1];
    assign wr_mask_b = wmsk_v[1];

    // Read side: combinational, decoded against the addressed channel
    logic    rd_active;
    reg_id_e rdec;

    uart2_rd_path u_rd (
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .chan_sel  (chan_sel),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b),
        .rd_active (rd_active),
        .rd_ch_a   (rd_ch_a),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    uart2_addr_map u_rmap (
        .addr   (addr),
        .cfg    (chan_sel ? cfg_v[0] : cfg_v[1]),
        .is_wr  (1'b0),
        .reg_id (rdec)
    );

    assign rd_reg = rd_active ? rdec : RG_NONE;

    p_both_need_bcast_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_a && wr_en_b) |-> $past(bcast_en));
    p_wen_on_rise_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en_a || wr_en_b) |-> ($past(wr_n) && !$past(wr_n, 2)));
    p_float_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_n || cs_n) |-> (!dout_oe && dout == '0));
    p_rd_chan_r3: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && !chan_sel) |-> (dout == rd_data_b && !rd_ch_a));
endmodule

// File: tb/uart2_regdec_tb.sv
module uart2_regdec_tb;
    import uart2_regdec_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, chan_sel = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] lcr_a = '0, lcr_b = '0;
    logic div_zero_a = 1'b0, div_zero_b = 1'b0;
    logic lvl_sel_a = 1'b0, lvl_sel_b = 1'b0;
    logic ext_unlock_a = 1'b1, ext_unlock_b = 1'b1;
    logic bcast_en = 1'b0;
    logic [7:0] rd_data_a = 8'h5A, rd_data_b = 8'hA5;
    logic wr_en_a, wr_en_b, rd_ch_a, dout_oe;
    logic [4:0] wr_reg_a, wr_reg_b, rd_reg;
    logic [7:0] wr_mask_a, wr_mask_b, wr_data, dout;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    uart2_regdec u_dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Strobe low for one edge, release, sample after the edge that sees it high
    task automatic do_write(input logic [2:0] a, input logic [7:0] d,
                            input logic cs, input logic ch);
        @(negedge clk);
        addr = a; wdata = d; cs_n = cs; chan_sel = ch; wr_n = 1'b0;
        @(negedge clk);
        chk("R8 no enable A while strobe low", int'(wr_en_a), 0);
        chk("R8 no enable B while strobe low", int'(wr_en_b), 0);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic end_write();
        cs_n = 1'b1;
    endtask

    task automatic wr_expect_a(input string tag, input logic [2:0] a, input reg_id_e r);
        do_write(a, 8'h3C, 1'b0, 1'b1);
        chk({tag, " enable A"}, int'(wr_en_a), (r == RG_NONE) ? 0 : 1);
        chk({tag, " enable B"}, int'(wr_en_b), 0);
        if (r != RG_NONE) chk({tag, " code A"}, int'(wr_reg_a), int'(r));
        end_write();
    endtask

    task automatic rd_expect(input string tag, input logic [2:0] a, input logic ch,
                             input reg_id_e r);
        @(negedge clk);
        addr = a; chan_sel = ch; cs_n = 1'b0; rd_n = 1'b0;
        #1;
        chk({tag, " read code"}, int'(rd_reg), int'(r));
        chk({tag, " read channel"}, int'(rd_ch_a), int'(ch));
        chk({tag, " read data"}, int'(dout), ch ? int'(rd_data_a) : int'(rd_data_b));
        chk({tag, " read oe"}, int'(dout_oe), 1);
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R8 reset enable A", int'(wr_en_a), 0);
        chk("R8 reset enable B", int'(wr_en_b), 0);
        chk("R9 reset oe", int'(dout_oe), 0);
        chk("R9 reset dout", int'(dout), 0);
    endtask

    task automatic t_standard();
        lcr_a = 8'h03;
        wr_expect_a("R12 addr0 write", 3'd0, RG_TXD);
        chk("R8 data captured", int'(wr_data), 8'h3C);
        wr_expect_a("R4 addr1 write", 3'd1, RG_IEN);
        wr_expect_a("R12 addr2 write", 3'd2, RG_FCT);
        wr_expect_a("R4 addr3 write", 3'd3, RG_LCT);
        wr_expect_a("R4 addr4 write", 3'd4, RG_MCT);
        wr_expect_a("R11 addr5 write ignored", 3'd5, RG_NONE);
        wr_expect_a("R11 addr6 write ignored", 3'd6, RG_NONE);
        wr_expect_a("R7 addr7 write scratch", 3'd7, RG_SCR);
        rd_expect("R12 addr0", 3'd0, 1'b1, RG_RXD);
        rd_expect("R12 addr2", 3'd2, 1'b1, RG_IST);
        rd_expect("R4 addr5", 3'd5, 1'b1, RG_LST);
        rd_expect("R4 addr6", 3'd6, 1'b1, RG_MST);
        rd_expect("R7 addr7 scratch", 3'd7, 1'b1, RG_SCR);
    endtask

    task automatic t_chan_b();
        lcr_b = 8'h00;
        do_write(3'd1, 8'h11, 1'b0, 1'b0);
        chk("R1 B write enable B", int'(wr_en_b), 1);
        chk("R1 B write enable A", int'(wr_en_a), 0);
        chk("R1 B write code", int'(wr_reg_b), int'(RG_IEN));
        end_write();
        @(negedge clk);
        chk("R8 pulse one cycle", int'(wr_en_b), 0);
        rd_expect("R1 B read", 3'd4, 1'b0, RG_MCT);
    endtask

    task automatic t_divisor();
        lcr_a = 8'h83; div_zero_a = 1'b1;
        wr_expect_a("R5 addr0", 3'd0, RG_DIVL);
        wr_expect_a("R5 addr1", 3'd1, RG_DIVH);
        wr_expect_a("R5 addr2 divisor zero", 3'd2, RG_ALT);
        wr_expect_a("R5 addr4", 3'd4, RG_MCT);
        div_zero_a = 1'b0;
        wr_expect_a("R5 addr2 divisor nonzero", 3'd2, RG_FCT);
        rd_expect("R5 addr2 divisor nonzero", 3'd2, 1'b1, RG_IST);
        div_zero_a = 1'b1;
        rd_expect("R5 addr2 divisor zero", 3'd2, 1'b1, RG_ALT);
    endtask

    task automatic t_ext_bank();
        lcr_a = 8'hBF; div_zero_a = 1'b1;
        wr_expect_a("R6 addr2", 3'd2, RG_EXT);
        wr_expect_a("R6 addr3", 3'd3, RG_LCT);
        wr_expect_a("R6 addr4", 3'd4, RG_XON1);
        wr_expect_a("R6 addr5", 3'd5, RG_XON2);
        wr_expect_a("R6 addr6", 3'd6, RG_XOFF1);
        wr_expect_a("R6 addr7", 3'd7, RG_XOFF2);
        rd_expect("R6 addr2", 3'd2, 1'b1, RG_EXT);
        rd_expect("R6 addr0", 3'd0, 1'b1, RG_DIVL);
    endtask

    task automatic t_level_sel();
        lcr_a = 8'h03; lvl_sel_a = 1'b1;
        wr_expect_a("R7 addr7 mode select", 3'd7, RG_MSEL);
        rd_expect("R7 addr7 fifo level", 3'd7, 1'b1, RG_FLVL);
        lvl_sel_a = 1'b0;
    endtask

    task automatic t_broadcast();
        bcast_en = 1'b1; lcr_a = 8'h00; lcr_b = 8'h80;
        do_write(3'd0, 8'h77, 1'b0, 1'b0);
        chk("R2 bcast enable A", int'(wr_en_a), 1);
        chk("R2 bcast enable B", int'(wr_en_b), 1);
        chk("R2 bcast code A", int'(wr_reg_a), int'(RG_TXD));
        chk("R2 bcast code B", int'(wr_reg_b), int'(RG_DIVL));
        chk("R2 bcast data", int'(wr_data), 8'h77);
        end_write();
        rd_expect("R3 bcast read B", 3'd0, 1'b0, RG_DIVL);
        rd_expect("R3 bcast read A", 3'd0, 1'b1, RG_RXD);
        bcast_en = 1'b0; lcr_b = 8'h00;
    endtask

    task automatic t_deselect();
        do_write(3'd1, 8'h22, 1'b1, 1'b1);
        chk("R8 cs high write A", int'(wr_en_a), 0);
        chk("R8 cs high write B", int'(wr_en_b), 0);
        @(negedge clk);
        addr = 3'd0; chan_sel = 1'b1; cs_n = 1'b1; rd_n = 1'b0;
        #1;
        chk("R9 cs high oe", int'(dout_oe), 0);
        chk("R9 cs high dout", int'(dout), 0);
        @(negedge clk);
        rd_n = 1'b1;
    endtask

    task automatic t_mask();
        lcr_a = 8'h00; ext_unlock_a = 1'b0;
        do_write(3'd1, 8'hFF, 1'b0, 1'b1);
        chk("R10 locked IEN mask", int'(wr_mask_a), 8'h0F); end_write();
        do_write(3'd2, 8'hFF, 1'b0, 1'b1);
        chk("R10 locked FCT mask", int'(wr_mask_a), 8'hCF); end_write();
        do_write(3'd4, 8'hFF, 1'b0, 1'b1);
        chk("R10 locked MCT mask", int'(wr_mask_a), 8'h1F); end_write();
        do_write(3'd3, 8'hFF, 1'b0, 1'b1);
        chk("R10 locked LCT mask", int'(wr_mask_a), 8'hFF); end_write();
        ext_unlock_a = 1'b1;
        do_write(3'd1, 8'hFF, 1'b0, 1'b1);
        chk("R10 unlocked IEN mask", int'(wr_mask_a), 8'hFF); end_write();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #200_000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_standard();
        t_chan_b();
        t_divisor();
        t_ext_bank();
        t_level_sel();
        t_broadcast();
        t_deselect();
        t_mask();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule